// File: doc/BRIEF.md
# Calendar Clock with Snapshot Latch

This block keeps wall-clock time and calendar date in seven binary counters: seconds, minutes, hours, weekday, day of month, month and two-digit year. A slow square wave from the subclock domain is brought into the bus clock domain through a flop synchronizer. Each of its rising edges becomes a single-cycle tick, and each tick advances the seconds counter. Carries ripple up the calendar chain in that same cycle. Month length follows the month, and February has 29 days in years divisible by four.

Software sets the time through a write strobe carrying a field address and a byte. Three plain control pins shape behaviour. The pause pin drops ticks so fields can be set without racing the clock. The snapshot pin freezes a coherent copy of every field for reading. The power-save pin locks out all writes, and read data is undefined while it is high. The write port has no back-pressure: every strobe is taken in the cycle it is presented, and a strobe is either applied or dropped in that cycle. The recommended way to set the clock is to release power-save, raise pause, write the fields, then drop pause.

Field addresses are shared by writes and reads: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset every field reads 0, except day of month and month, which read 1.
- R2: Each rising edge of `sub_tick` advances seconds by exactly one. With no pause, the new value is readable from the third bus clock edge after the first edge that samples `sub_tick` high.
- R3: Seconds and minutes wrap from 59 to 0, hours wrap from 23 to 0, and weekday wraps from 6 to 0. Each wrap carries one increment into the next field in the same cycle. The hour wrap advances both weekday and day of month.
- R4: Day of month wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days and February has 28 days, or 29 when year mod 4 is 0; all other months have 31 days. Month wraps from 12 to 1 and carries into year, and year wraps from 99 to 0.
- R5: While `ctl_pause` is 1, every tick is discarded and no field changes.
- R6: A write with `wr_valid` high, `ctl_psave` low and `wr_addr` 0 to 6 loads `wr_data` into the addressed field at the next clock edge. This holds whether or not ticking is paused.
- R7: When a write and a tick increment reach the same field in one cycle, the written value is kept. The other fields still advance.
- R8: In the cycle `ctl_snap` goes from 0 to 1, all seven field values are captured together.
- R9: While `ctl_snap` stays 1, reads return the captured values even as the counters advance.
- R10: From the first clock edge after `ctl_snap` returns to 0, reads follow the live counters.
- R11: While `ctl_psave` is 1, writes are ignored and no field changes because of them.
- R12: A read at address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, at least four times the subclock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | One-hertz square wave from the subclock domain |
| ctl_pause | input | 1 | Discard ticks while high |
| ctl_snap | input | 1 | Rising edge captures a snapshot; held high keeps it |
| ctl_psave | input | 1 | Power-save: writes locked out, reads undefined |
| wr_valid | input | 1 | Write strobe, always accepted |
| wr_addr | input | 3 | Field address for the write |
| wr_data | input | 8 | Binary value to write |
| rd_addr | input | 3 | Field address for the read |
| rd_data | output | 8 | Combinational read data |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, year limit 99 and leap period 4. These values keep every calendar boundary within a few ticks. The fields are written next to their limits, so the year wrap, both February lengths and a 30-day month are each reached with a single tick. The two-stage synchronizer gives a fixed three-edge tick latency. That fixed latency lets the bench place a write in exactly the cycle of a tick increment.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NF = 7;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_MDAY = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } field_e;

  typedef logic [NF-1:0][DW-1:0] fields_t;

  function automatic logic [DW-1:0] month_days(input logic [DW-1:0] mon, input logic leap);
    logic [DW-1:0] d;
    case (mon)
      8'd2:                     d = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
      default:                  d = 8'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic pause,
  output logic tick_en
);
  logic [SYNC_STAGES:0] sh;
  logic                 pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], sub_tick};
  end

  assign pulse   = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign tick_en = pulse & ~pause;

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  p_pause_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pause |-> !tick_en);
endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
  parameter int W   = 8,
  parameter int LOW = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic [W-1:0] top,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         at_top
);
  localparam logic [W-1:0] LOWV = W'(LOW);

  assign at_top = (q >= top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= LOWV;
    else if (wr)  q <= wdata;
    else if (inc) q <= at_top ? LOWV : q + W'(1);
  end

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(wdata)));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && at_top) |=> (q == LOWV));
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
#(
  parameter int YEAR_MAX = 99,
  parameter int LEAP_MOD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          psave,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output fields_t       live
);
  localparam logic [DW-1:0] YMAX = DW'(YEAR_MAX);
  localparam logic [DW-1:0] LMOD = DW'(LEAP_MOD);

  logic [NF-1:0]         inc, at, wr;
  logic [NF-1:0][DW-1:0] top;
  logic                  leap;
  logic                  wr_ok;

  assign wr_ok = wr_valid & ~psave;
  assign leap  = ((live[F_YEAR] % LMOD) == '0);

  always_comb begin
    top[F_SEC]  = 8'd59;
    top[F_MIN]  = 8'd59;
    top[F_HOUR] = 8'd23;
    top[F_WDAY] = 8'd6;
    top[F_MDAY] = month_days(live[F_MON], leap);
    top[F_MON]  = 8'd12;
    top[F_YEAR] = YMAX;
  end

  always_comb begin
    inc[F_SEC]  = tick_en;
    inc[F_MIN]  = inc[F_SEC]  & at[F_SEC];
    inc[F_HOUR] = inc[F_MIN]  & at[F_MIN];
    inc[F_WDAY] = inc[F_HOUR] & at[F_HOUR];
    inc[F_MDAY] = inc[F_HOUR] & at[F_HOUR];
    inc[F_MON]  = inc[F_MDAY] & at[F_MDAY];
    inc[F_YEAR] = inc[F_MON]  & at[F_MON];
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    localparam int LO = (i == F_MDAY || i == F_MON) ? 1 : 0;
    assign wr[i] = wr_ok && (wr_addr == AW'(i));
    rtc_field #(.W(DW), .LOW(LO)) u_fld (
      .clk(clk), .rst_n(rst_n), .inc(inc[i]), .top(top[i]),
      .wr(wr[i]), .wdata(wr_data), .q(live[i]), .at_top(at[i])
    );
  end

  p_psave_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (psave && !tick_en) |=> $stable(live));
  p_pause_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_ok) |=> $stable(live));
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snap,
  input  fields_t       live,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  fields_t held;
  logic    snap_q;
  fields_t view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= 1'b0;
      held   <= '0;
    end else begin
      snap_q <= snap;
      if (!snap_q) held <= live;
    end
  end

  assign view    = snap_q ? held : live;
  assign rd_data = (rd_addr < AW'(NF)) ? view[rd_addr] : '0;

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snap && !snap_q) |=> (held == $past(live)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q && snap) |=> $stable(held));
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
  import rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int YEAR_MAX    = 99,
  parameter int LEAP_MOD    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sub_tick,
  input  logic          ctl_pause,
  input  logic          ctl_snap,
  input  logic          ctl_psave,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic    tick_en;
  fields_t live;

  rtc_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .pause(ctl_pause), .tick_en(tick_en)
  );

  rtc_counters #(.YEAR_MAX(YEAR_MAX), .LEAP_MOD(LEAP_MOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psave(ctl_psave),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .live(live)
  );

  rtc_snapshot u_snap (
    .clk(clk), .rst_n(rst_n), .snap(ctl_snap), .live(live),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  p_read_pad_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd7) |-> (rd_data == 8'd0));
endmodule

// File: tb/tb_rtc_calendar_top.sv
module tb_rtc_calendar_top;
  logic       clk = 0, rst_n = 0, sub_tick = 0;
  logic       ctl_pause = 0, ctl_snap = 0, ctl_psave = 0, wr_valid = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  int errors = 0, checks = 0;

  rtc_calendar_top dut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .ctl_pause(ctl_pause),
    .ctl_snap(ctl_snap), .ctl_psave(ctl_psave), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 3'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic tick();
    @(negedge clk); sub_tick = 1;
    repeat (3) @(negedge clk);
    sub_tick = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_all(input int s, input int m, input int h, input int w,
                         input int d, input int mo, input int y);
    ctl_pause = 1;
    wr(0, s); wr(1, m); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
    ctl_pause = 0;
  endtask

  task automatic t_reset();
    int v;
    int exp[7] = '{0, 0, 0, 0, 1, 1, 0};
    for (int i = 0; i < 7; i++) begin rd(i, v); chk("R1 reset field", v, exp[i]); end
    rd(7, v); chk("R12 pad address", v, 0);
  endtask

  task automatic t_tick_latency();
    int v;
    set_all(5, 0, 0, 0, 1, 1, 0);
    rd(0, v); chk("R6 write sec", v, 5);
    @(negedge clk); sub_tick = 1;
    @(negedge clk); @(negedge clk);
    rd_addr = 0; #1 chk("R2 not yet", int'(rd_data), 5);
    @(negedge clk); #1 chk("R2 third edge", int'(rd_data), 6);
    sub_tick = 0; repeat (3) @(negedge clk);
    rd(0, v); chk("R2 one per edge", v, 6);
  endtask

  task automatic t_rollover();
    int v;
    int exp[7] = '{0, 0, 0, 0, 1, 1, 0};
    set_all(59, 59, 23, 6, 31, 12, 99);
    tick();
    for (int i = 0; i < 7; i++) begin rd(i, v); chk("R3/R4 full wrap", v, exp[i]); end
    set_all(59, 58, 4, 2, 9, 9, 9);
    tick();
    rd(1, v); chk("R3 min carry", v, 59);
    rd(2, v); chk("R3 hour kept", v, 4);
  endtask

  task automatic t_months();
    int v;
    set_all(59, 59, 23, 0, 28, 2, 24);
    tick();
    rd(4, v); chk("R4 leap feb 29", v, 29);
    rd(3, v); chk("R3 wday step", v, 1);
    set_all(59, 59, 23, 0, 28, 2, 23);
    tick();
    rd(4, v); chk("R4 feb 28 wrap", v, 1);
    rd(5, v); chk("R4 to march", v, 3);
    set_all(59, 59, 23, 0, 30, 4, 23);
    tick();
    rd(4, v); chk("R4 april 30", v, 1);
    rd(5, v); chk("R4 to may", v, 5);
    set_all(59, 59, 23, 0, 30, 5, 23);
    tick();
    rd(4, v); chk("R4 may 31", v, 31);
  endtask

  task automatic t_pause();
    int v;
    set_all(20, 1, 1, 1, 1, 1, 1);
    ctl_pause = 1;
    tick(); tick(); tick();
    rd(0, v); chk("R5 paused", v, 20);
    ctl_pause = 0;
    tick();
    rd(0, v); chk("R5 resumed", v, 21);
  endtask

  task automatic t_collide();
    int v;
    set_all(59, 10, 1, 1, 1, 1, 1);
    @(negedge clk); sub_tick = 1;
    @(negedge clk); @(negedge clk);
    wr_valid = 1; wr_addr = 3'd0; wr_data = 8'd33;
    @(negedge clk); wr_valid = 0;
    sub_tick = 0; repeat (3) @(negedge clk);
    rd(0, v); chk("R7 write wins", v, 33);
    rd(1, v); chk("R7 others advance", v, 11);
  endtask

  task automatic t_snapshot();
    int v;
    set_all(10, 7, 3, 2, 5, 6, 7);
    @(negedge clk); ctl_snap = 1;
    tick(); tick();
    rd(0, v); chk("R9 held sec", v, 10);
    rd(1, v); chk("R8 held min", v, 7);
    rd(4, v); chk("R8 held day", v, 5);
    @(negedge clk); ctl_snap = 0;
    rd(0, v); chk("R10 live again", v, 12);
    tick();
    rd(0, v); chk("R10 follows", v, 13);
  endtask

  task automatic t_psave();
    int v;
    set_all(40, 41, 2, 2, 2, 2, 2);
    ctl_pause = 1; ctl_psave = 1;
    wr(0, 5); wr(1, 6); wr(6, 50);
    ctl_psave = 0;
    rd(0, v); chk("R11 sec locked", v, 40);
    rd(1, v); chk("R11 min locked", v, 41);
    rd(6, v); chk("R11 year locked", v, 2);
    wr(0, 5);
    rd(0, v); chk("R6 write after psave", v, 5);
    ctl_pause = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tick_latency();
        t_rollover();
        t_months();
        t_pause();
        t_collide();
        t_snapshot();
        t_psave();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule